// File: doc/BRIEF.md
# AHB-Lite to APB Peripheral Bridge

This block sits on an AHB-Lite bus as a slave and turns each accepted AHB single transfer into one non-pipelined APB access with two phases. It registers the address, the direction and the target peripheral in the AHB address phase. It then holds the AHB side in wait states through its ready output while the APB side runs one SETUP cycle and one ENABLE cycle. A second-level decoder picks one of several peripheral select lines from a field of the registered address. Read data from the selected peripheral goes back on the AHB read data bus.

A compile-time parameter chooses how read data comes back. In pass-through mode the peripheral data is routed combinationally in the ENABLE cycle, and the bridge releases the AHB bus in that same cycle. In registered mode the bridge adds one more wait state and returns the data from a flop in the following cycle. Writes behave the same in both modes. When a transfer is offered in the cycle that completes the previous one, the bridge goes straight into the next SETUP cycle.

Top module: `ahb_apb_bridge`

## Requirements
- R1: While reset is active, every bit of `psel` is 0, `penable` is 0, `pwrite` is 0 and `hreadyout` is 1.
- R2: A transfer is accepted at a rising edge where `hsel`=1, `hready`=1 and `htrans` is NONSEQ (2'b10) or SEQ (2'b11), and the bridge's `hreadyout` is 1. The next cycle is SETUP: the target select is 1, `penable` is 0, `hreadyout` is 0, `paddr` equals the accepted `haddr` and `pwrite` equals the accepted `hwrite`.
- R3: The cycle after SETUP is ENABLE. It lasts exactly one cycle, with the same select still high and `penable` high.
- R4: The peripheral index is `haddr[SEL_LSB +: SEL_W]` (bits 13:12 by default). Index i < NUM_SLV (3 by default) drives only `psel[i]`. An index of NUM_SLV or above drives no select and no `penable`, keeps the same SETUP/ENABLE timing, and returns 0 on reads.
- R5: For a write, `pwdata` equals the `hwdata` presented in the cycle after the address phase. It holds that value through both SETUP and ENABLE, and `hreadyout` returns to 1 in ENABLE.
- R6: In pass-through mode (REG_RDATA=0), during a read ENABLE cycle `hreadyout` is 1 and `hrdata` equals the selected slice of `prdata_bus`.
- R7: In registered mode (REG_RDATA=1), `hreadyout` is 0 during a read ENABLE cycle. In the following cycle `hreadyout` is 1, `hrdata` holds the value read, and no select is high.
- R8: IDLE (2'b00) or BUSY (2'b01) transfers, or `hsel`=0, cause no APB activity, and `hreadyout` stays 1.
- R9: A transfer accepted in the cycle that completes the previous one starts its SETUP cycle at the very next edge.
- R10: `paddr` and `pwdata` keep their last values between transfers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Clock |
| hresetn | input | 1 | Active-low reset |
| hsel | input | 1 | Bridge selected by the AHB decoder |
| haddr | input | ADDR_W | AHB address |
| htrans | input | 2 | AHB transfer type |
| hwrite | input | 1 | AHB direction, 1 = write |
| hwdata | input | DATA_W | AHB write data |
| hready | input | 1 | AHB bus ready (previous transfer completing) |
| hreadyout | output | 1 | Bridge ready, 0 inserts a wait state |
| hrdata | output | DATA_W | AHB read data |
| psel | output | NUM_SLV | One-hot peripheral selects |
| penable | output | 1 | APB ENABLE phase |
| pwrite | output | 1 | APB direction, 1 = write |
| paddr | output | ADDR_W | APB address |
| pwdata | output | DATA_W | APB write data |
| prdata_bus | input | NUM_SLV*DATA_W | Read data of all peripherals, slave i in slice i |

## Verification
Every peripheral index is swept with both directions, both valid transfer types and several address offsets, including the unmapped index. This separates decode errors from phase-timing errors and shows that the unmapped index keeps its timing but drives no select. The same sweep runs on a pass-through instance and on a registered-read instance, which tells the same-cycle return apart from the extra wait state. Runs of IDLE, BUSY and deselected cycles show that nothing reaches the APB side. A write followed at once by a read shows that the pipelined address is taken without an idle gap.

// File: rtl/ahb_apb_bridge.sv
`timescale 1ns/1ps
module ahb_apb_bridge #(
  parameter int ADDR_W    = 32,
  parameter int DATA_W    = 32,
  parameter int NUM_SLV   = 3,
  parameter int SEL_W     = 2,
  parameter int SEL_LSB   = 12,
  parameter bit REG_RDATA = 1'b0
) (
  input  logic                      hclk,
  input  logic                      hresetn,
  input  logic                      hsel,
  input  logic [ADDR_W-1:0]         haddr,
  input  logic [1:0]                htrans,
  input  logic                      hwrite,
  input  logic [DATA_W-1:0]         hwdata,
  input  logic                      hready,
  output logic                      hreadyout,
  output logic [DATA_W-1:0]         hrdata,
  output logic [NUM_SLV-1:0]        psel,
  output logic                      penable,
  output logic                      pwrite,
  output logic [ADDR_W-1:0]         paddr,
  output logic [DATA_W-1:0]         pwdata,
  input  logic [NUM_SLV*DATA_W-1:0] prdata_bus
);

  typedef enum logic [1:0] {S_IDLE, S_SETUP, S_ENABLE, S_RDONE} state_t;

  state_t            st, st_nx;
  logic [SEL_W-1:0]  idx_q;
  logic [DATA_W-1:0] pwdata_q;
  logic [DATA_W-1:0] rd_sel;
  logic              take, hit, phase, rd_enable;

  assign take      = hreadyout && hsel && hready && (htrans == 2'b10 || htrans == 2'b11);
  assign hit       = (int'(idx_q) < NUM_SLV);
  assign phase     = (st == S_SETUP) || (st == S_ENABLE);
  assign rd_enable = (st == S_ENABLE) && !pwrite;
  assign penable   = (st == S_ENABLE) && hit;
  assign hreadyout = (st == S_IDLE) || (st == S_RDONE) ||
                     ((st == S_ENABLE) && (!REG_RDATA || pwrite));
  assign pwdata    = ((st == S_SETUP) && pwrite) ? hwdata : pwdata_q;

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE:   st_nx = take ? S_SETUP : S_IDLE;
      S_SETUP:  st_nx = S_ENABLE;
      S_ENABLE: if (REG_RDATA && !pwrite) st_nx = S_RDONE;
                else                      st_nx = take ? S_SETUP : S_IDLE;
      S_RDONE:  st_nx = take ? S_SETUP : S_IDLE;
      default:  st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge hclk or negedge hresetn) begin
    if (!hresetn) begin
      st       <= S_IDLE;
      paddr    <= '0;
      pwrite   <= 1'b0;
      idx_q    <= '0;
      pwdata_q <= '0;
    end else begin
      st <= st_nx;
      if (take) begin
        paddr  <= haddr;
        pwrite <= hwrite;
        idx_q  <= haddr[SEL_LSB +: SEL_W];
      end
      if (st == S_SETUP && pwrite) pwdata_q <= hwdata;
    end
  end

  genvar gi;
  generate
    for (gi = 0; gi < NUM_SLV; gi++) begin : g_sel
      assign psel[gi] = phase && (idx_q == SEL_W'(gi));
    end
  endgenerate

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < NUM_SLV; i++)
      if (idx_q == SEL_W'(i)) rd_sel = prdata_bus[i*DATA_W +: DATA_W];
  end

  generate
    if (REG_RDATA) begin : g_reg_rd
      logic [DATA_W-1:0] rdata_q;
      always_ff @(posedge hclk or negedge hresetn) begin
        if (!hresetn)       rdata_q <= '0;
        else if (rd_enable) rdata_q <= rd_sel;
      end
      assign hrdata = rdata_q;

      a_r7_read_wait: assert property (@(posedge hclk) disable iff (!hresetn)
        (penable && !pwrite) |-> !hreadyout) else $error("a_r7_read_wait");
      a_r7_read_release: assert property (@(posedge hclk) disable iff (!hresetn)
        (penable && !pwrite) |=> (hreadyout && psel == '0)) else $error("a_r7_read_release");
    end else begin : g_pass_rd
      assign hrdata = rd_enable ? rd_sel : '0;

      a_r6_same_cycle: assert property (@(posedge hclk) disable iff (!hresetn)
        penable |-> hreadyout) else $error("a_r6_same_cycle");
    end
  endgenerate

  a_r1_reset_idle: assert property (@(posedge hclk)
    !hresetn |-> (psel == '0 && !penable && !pwrite && hreadyout)) else $error("a_r1_reset_idle");

  a_r2_stall_setup: assert property (@(posedge hclk) disable iff (!hresetn)
    (|psel && !penable) |-> !hreadyout) else $error("a_r2_stall_setup");

  a_r3_setup_to_enable: assert property (@(posedge hclk) disable iff (!hresetn)
    (|psel && !penable) |=> (penable && $stable(psel))) else $error("a_r3_setup_to_enable");

  a_r3_enable_once: assert property (@(posedge hclk) disable iff (!hresetn)
    penable |=> !penable) else $error("a_r3_enable_once");

  a_r4_psel_onehot: assert property (@(posedge hclk) disable iff (!hresetn)
    $onehot0(psel)) else $error("a_r4_psel_onehot");

  a_r10_hold_in_enable: assert property (@(posedge hclk) disable iff (!hresetn)
    penable |-> ($stable(paddr) && $stable(pwdata))) else $error("a_r10_hold_in_enable");

  a_r8_no_spurious: assert property (@(posedge hclk) disable iff (!hresetn)
    (hreadyout && !(hsel && hready && htrans[1])) |=> (psel == '0)) else $error("a_r8_no_spurious");

endmodule

// File: tb/ahb_apb_bridge_tb.sv
`timescale 1ns/1ps
module ahb_apb_bridge_tb;
  localparam int NS = 3;

  logic clk = 1'b0, rstn = 1'b0;
  always #2 clk = ~clk;

  logic hsel_a = 0, hsel_b = 0, hwrite = 0;
  logic [31:0] haddr = '0, hwdata = '0;
  logic [1:0]  htrans = '0;

  logic rdy_a, rdy_b, pen_a, pen_b, pwr_a, pwr_b;
  logic [31:0] hrd_a, hrd_b, pad_a, pad_b, pwd_a, pwd_b;
  logic [NS-1:0] ps_a, ps_b;
  logic [NS*32-1:0] prd_a, prd_b;

  for (genvar i = 0; i < NS; i++) begin : g_slv
    assign prd_a[i*32 +: 32] = {pad_a[15:0] ^ 16'hA5A5, 8'(i), 8'h3C};
    assign prd_b[i*32 +: 32] = {pad_b[15:0] ^ 16'hA5A5, 8'(i), 8'h3C};
  end

  ahb_apb_bridge #(.REG_RDATA(1'b0)) u_dut (
    .hclk(clk), .hresetn(rstn), .hsel(hsel_a), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hwdata(hwdata), .hready(rdy_a), .hreadyout(rdy_a),
    .hrdata(hrd_a), .psel(ps_a), .penable(pen_a), .pwrite(pwr_a), .paddr(pad_a),
    .pwdata(pwd_a), .prdata_bus(prd_a));

  ahb_apb_bridge #(.REG_RDATA(1'b1)) u_dut_reg (
    .hclk(clk), .hresetn(rstn), .hsel(hsel_b), .haddr(haddr), .htrans(htrans),
    .hwrite(hwrite), .hwdata(hwdata), .hready(rdy_b), .hreadyout(rdy_b),
    .hrdata(hrd_b), .psel(ps_b), .penable(pen_b), .pwrite(pwr_b), .paddr(pad_b),
    .pwdata(pwd_b), .prdata_bus(prd_b));

  logic use_b = 0;
  wire        c_rdy = use_b ? rdy_b : rdy_a;
  wire        c_pen = use_b ? pen_b : pen_a;
  wire        c_pwr = use_b ? pwr_b : pwr_a;
  wire [31:0] c_hrd = use_b ? hrd_b : hrd_a;
  wire [31:0] c_pad = use_b ? pad_b : pad_a;
  wire [31:0] c_pwd = use_b ? pwd_b : pwd_a;
  wire [NS-1:0] c_ps = use_b ? ps_b : ps_a;

  int checks = 0, fails = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] exp_rd(input logic [31:0] a);
    int ix = int'(a[13:12]);
    if (ix >= NS) return 32'h0;
    return {a[15:0] ^ 16'hA5A5, 8'(ix), 8'h3C};
  endfunction

  function automatic logic [NS-1:0] exp_sel(input logic [31:0] a);
    int ix = int'(a[13:12]);
    return (ix < NS) ? NS'(1 << ix) : '0;
  endfunction

  task automatic xfer(input bit b, input bit wr, input logic [1:0] tr,
                      input logic [31:0] a, input logic [31:0] wd);
    bit hit = int'(a[13:12]) < NS;
    use_b = b;
    @(negedge clk);
    hsel_a = !b; hsel_b = b; htrans = tr; haddr = a; hwrite = wr;
    @(negedge clk);
    hsel_a = 0; hsel_b = 0; htrans = 2'b00; hwdata = wd;
    #0.5;
    chk("R2/R4 setup psel", 32'(c_ps), 32'(exp_sel(a)));
    chk("R2 setup penable", 32'(c_pen), 0);
    chk("R2 setup hreadyout", 32'(c_rdy), 0);
    chk("R2 setup paddr", c_pad, a);
    chk("R2 setup pwrite", 32'(c_pwr), 32'(wr));
    if (wr) chk("R5 setup pwdata", c_pwd, wd);
    @(negedge clk);
    chk("R3/R4 enable psel", 32'(c_ps), 32'(exp_sel(a)));
    chk("R3/R4 enable penable", 32'(c_pen), 32'(hit));
    if (wr) begin
      chk("R5 enable pwdata", c_pwd, wd);
      chk("R5 enable hreadyout", 32'(c_rdy), 1);
    end else if (!b) begin
      chk("R6 enable hreadyout", 32'(c_rdy), 1);
      chk("R6/R4 hrdata", c_hrd, exp_rd(a));
    end else begin
      chk("R7 enable hreadyout", 32'(c_rdy), 0);
      @(negedge clk);
      chk("R7 done hreadyout", 32'(c_rdy), 1);
      chk("R7/R4 done hrdata", c_hrd, exp_rd(a));
      chk("R7 done psel", 32'(c_ps), 0);
    end
    @(negedge clk);
    chk("R3 after penable", 32'(c_pen), 0);
    chk("R10 idle psel", 32'(c_ps), 0);
    chk("R10 hold paddr", c_pad, a);
    if (wr) chk("R10 hold pwdata", c_pwd, wd);
  endtask

  logic [31:0] last_pwd_a, last_pwd_b;

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset psel", 32'(ps_a) | 32'(ps_b), 0);
    chk("R1 reset penable", 32'(pen_a | pen_b), 0);
    chk("R1 reset pwrite", 32'(pwr_a | pwr_b), 0);
    chk("R1 reset hreadyout", 32'(rdy_a & rdy_b), 1);
    rstn = 1;

    for (int b = 0; b < 2; b++)
      for (int ix = 0; ix < 4; ix++)
        for (int wr = 0; wr < 2; wr++)
          for (int k = 0; k < 3; k++) begin
            logic [31:0] a = {16'h4000 + 16'(k * 7 + ix), 2'b00, 2'(ix), 12'(k * 12'h55C)};
            logic [31:0] d = {8'(b), 8'(ix), 8'(wr), 8'(k)} ^ 32'h5A3C_0F96;
            xfer(b[0], wr[0], (k == 1) ? 2'b11 : 2'b10, a, d);
          end

    last_pwd_a = pwd_a; last_pwd_b = pwd_b;
    for (int m = 0; m < 3; m++) begin
      @(negedge clk);
      haddr = 32'h0000_1000; hwrite = 1; hwdata = 32'hDEAD_BEEF;
      hsel_a = (m != 2); hsel_b = (m != 2);
      htrans = (m == 0) ? 2'b00 : (m == 1) ? 2'b01 : 2'b10;
      repeat (2) begin
        @(negedge clk);
        chk("R8 no psel", 32'(ps_a) | 32'(ps_b), 0);
        chk("R8 no penable", 32'(pen_a | pen_b), 0);
        chk("R8 hreadyout high", 32'(rdy_a & rdy_b), 1);
        chk("R8/R10 pwdata kept", pwd_a ^ pwd_b, last_pwd_a ^ last_pwd_b);
      end
    end
    hsel_a = 0; hsel_b = 0; htrans = 2'b00;

    use_b = 0;
    @(negedge clk);
    hsel_a = 1; htrans = 2'b10; haddr = 32'h0000_1010; hwrite = 1;
    @(negedge clk);
    haddr = 32'h0000_2024; hwrite = 0; htrans = 2'b11; hwdata = 32'h1234_5678;
    #0.5;
    chk("R9 first setup psel", 32'(ps_a), 32'b010);
    @(negedge clk);
    chk("R9 first enable pwdata", pwd_a, 32'h1234_5678);
    chk("R9 first enable hreadyout", 32'(rdy_a), 1);
    @(negedge clk);
    hsel_a = 0; htrans = 2'b00;
    chk("R9 back-to-back psel", 32'(ps_a), 32'b100);
    chk("R9 back-to-back penable", 32'(pen_a), 0);
    chk("R9 back-to-back paddr", pad_a, 32'h0000_2024);
    chk("R9 back-to-back pwrite", 32'(pwr_a), 0);
    @(negedge clk);
    chk("R9 second read hrdata", hrd_a, exp_rd(32'h0000_2024));
    @(negedge clk);
    chk("R9 back to idle", 32'(ps_a), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule